// File: doc/BRIEF.md
# Flash Memory Controller with Erase Commands

This block fronts a byte-addressable non-volatile storage array made of fixed-size pages, plus a small separate configuration region. Software reaches a handful of control registers through a simple single-cycle register port (valid, write, address, data, byte enables). A second port, the data port, reads and writes 32-bit words with byte enables in both storage regions.

A mode register gates every change to storage. Data writes land only in write-enable mode. Three kinds of erase command act only in erase mode: erase one page, erase the whole main array, or erase the configuration region. Every erase leaves each affected byte at 0xFF. Page erase has two aliased command offsets. Every operation finishes in the cycle it is accepted, so the ready status never drops.

The page size, the page count, the configuration region size and its base address are parameters. Flash timing, wear and read protection are not modelled.

Top module: `flashctl`

## Requirements
- R1: A register read of offset 0x400 returns 1 in bit 0, in the cycle after the read is accepted and at every point in time.
- R2: The mode register at offset 0x504 holds a 2-bit value (0 read-only, 1 write-enable, 2 erase-enable, 3 reserved). Reset clears it to 0. A write with byte enable bit 0 set stores wdata[1:0], and a write without that bit leaves it unchanged. A read returns the stored value, including 3, in bits [1:0] with all other bits zero.
- R3: A data-port write updates byte lane i (wdata bits 8i+7:8i) of the addressed word for each set byte enable bit i, in either region, only while the mode is 1. In modes 0, 2 and 3 the stored word is unchanged.
- R4: A data-port read returns its word in the cycle after it is accepted. The main array occupies byte addresses 0 to PAGE_BYTES*NUM_PAGES-1, and the configuration region occupies CFG_BASE to CFG_BASE+CFG_BYTES-1. Any other address reads 0. After reset every stored byte is 0xFF.
- R5: In mode 2, a register write to offset 0x508 or 0x510 erases the main-array page holding byte address wdata (page = wdata / PAGE_BYTES) to all 0xFF. Other pages keep their contents. A wdata at or beyond the end of the main array erases nothing.
- R6: In mode 2, a register write to offset 0x50C with wdata bit 0 set erases the whole main array to 0xFF. The configuration region is unchanged. With bit 0 clear, the write does nothing.
- R7: In mode 2, a register write to offset 0x514 with wdata bit 0 set erases the configuration region to 0xFF. The main array is unchanged.
- R8: The erase commands of R5 to R7 have no effect in modes 0, 1 and 3.
- R9: Register reads of any offset other than 0x400 and 0x504 return 0, and this includes the erase command offsets. Register writes to undefined offsets change neither storage nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rg_valid | input | 1 | Register access strobe |
| rg_write | input | 1 | 1 = register write, 0 = register read |
| rg_addr | input | 12 | Register byte offset |
| rg_wdata | input | 32 | Register write data |
| rg_be | input | 4 | Register byte enables |
| rg_rdata | output | 32 | Register read data, one cycle after the read |
| dp_valid | input | 1 | Data-port access strobe |
| dp_write | input | 1 | 1 = data write, 0 = data read |
| dp_addr | input | 32 | Data-port byte address (word aligned) |
| dp_wdata | input | 32 | Data-port write data |
| dp_be | input | 4 | Data-port byte enables |
| dp_rdata | output | 32 | Data-port read data, one cycle after the read |

## Verification
The bench goes after the places where the mode and storage gating is easy to get wrong. Writes are attempted in modes 0, 2 and 3, and erases in modes 1 and 3; a design with a loose mode compare would change storage in those cases. Page erases use an address in the middle of a page and go through both aliased offsets, and one targets an address past the array. A design that drops the modulo, decodes only one alias or fails to range-check would wipe the wrong page or no page. The bench also checks that a full erase spares the configuration region, that a full erase with bit 0 clear does nothing, and that a partial byte-enable write keeps the untouched lanes. A design that merged the erase targets or ignored the byte enables would show corrupted neighbouring data.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_READY    = 12'h400;
  localparam logic [REG_AW-1:0] OFS_MODE     = 12'h504;
  localparam logic [REG_AW-1:0] OFS_PGERA_A  = 12'h508;
  localparam logic [REG_AW-1:0] OFS_ALLERA   = 12'h50C;
  localparam logic [REG_AW-1:0] OFS_PGERA_B  = 12'h510;
  localparam logic [REG_AW-1:0] OFS_CFGERA   = 12'h514;

  typedef enum logic [1:0] {
    MODE_RO  = 2'd0,
    MODE_WR  = 2'd1,
    MODE_ER  = 2'd2,
    MODE_RSV = 2'd3
  } fmode_e;

  typedef struct packed {
    logic        pg_en;
    logic [31:0] pg_addr;
    logic        all_en;
    logic        cfg_en;
  } erase_cmd_t;

endpackage

// File: rtl/flashctl_regs.sv
module flashctl_regs
  import flashctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rg_valid,
  input  logic              rg_write,
  input  logic [REG_AW-1:0] rg_addr,
  input  logic [31:0]       rg_wdata,
  input  logic [3:0]        rg_be,
  output logic [31:0]       rg_rdata,
  output fmode_e            mode,
  output erase_cmd_t        cmd
);

  fmode_e mode_q;
  logic   wr_hit;
  logic   rd_hit;
  logic   erase_ok;

  assign wr_hit = rg_valid && rg_write;
  assign rd_hit = rg_valid && !rg_write;
  assign mode   = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RO;
    end else if (wr_hit && rg_addr == OFS_MODE && rg_be[0]) begin
      mode_q <= fmode_e'(rg_wdata[1:0]);
    end
  end

  always_comb begin
    erase_ok    = wr_hit && (mode_q == MODE_ER);
    cmd.pg_en   = erase_ok && (rg_addr == OFS_PGERA_A || rg_addr == OFS_PGERA_B);
    cmd.pg_addr = rg_wdata;
    cmd.all_en  = erase_ok && (rg_addr == OFS_ALLERA) && rg_wdata[0];
    cmd.cfg_en  = erase_ok && (rg_addr == OFS_CFGERA) && rg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rg_rdata <= '0;
    end else if (rd_hit) begin
      case (rg_addr)
        OFS_READY: rg_rdata <= 32'h1;
        OFS_MODE:  rg_rdata <= {30'b0, mode_q};
        default:   rg_rdata <= '0;
      endcase
    end
  end

  logic unused_be;
  assign unused_be = ^rg_be[3:1];

  // R1
  ready_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rg_valid && !rg_write && rg_addr == OFS_READY) |=> rg_rdata == 32'h1);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rg_valid && rg_write && rg_addr == OFS_MODE && rg_be[0]) |=> $stable(mode_q));

  // R8
  erase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.pg_en, cmd.all_en, cmd.cfg_en}));

endmodule

// File: rtl/flashctl_array.sv
module flashctl_array #(
  parameter int PAGE_WORDS = 256,
  parameter int PAGES      = 4,
  localparam int WORDS     = PAGE_WORDS * PAGES,
  localparam int IW        = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int PW        = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    wr_be,
  input  logic          pg_erase,
  input  logic [PW-1:0] pg_idx,
  input  logic          all_erase,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (rst || all_erase || (pg_erase && (w / PAGE_WORDS) == int'(pg_idx))) begin
        mem[w] <= '1;
      end else if (wr_en && w == int'(wr_idx)) begin
        for (int b = 0; b < 4; b++) begin
          if (wr_be[b]) mem[w][8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= mem[rd_idx];
    end
  end

  // R6, R7
  erase_all_fill_chk: assert property (@(posedge clk) disable iff (rst)
    all_erase |=> (mem[0] == '1 && mem[WORDS-1] == '1));

  // R5
  page_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (pg_erase && !all_erase) |=> mem[int'($past(pg_idx)) * PAGE_WORDS] == '1);

  // R3
  wr_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be[0] && !pg_erase && !all_erase)
      |=> mem[$past(wr_idx)][7:0] == $past(wr_data[7:0]));

endmodule

// File: rtl/flashctl.sv
module flashctl
  import flashctl_pkg::*;
#(
  parameter int          PAGE_BYTES = 1024,
  parameter int          NUM_PAGES  = 4,
  parameter int          CFG_BYTES  = 256,
  parameter logic [31:0] CFG_BASE   = 32'h1000_1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rg_valid,
  input  logic        rg_write,
  input  logic [11:0] rg_addr,
  input  logic [31:0] rg_wdata,
  input  logic [3:0]  rg_be,
  output logic [31:0] rg_rdata,
  input  logic        dp_valid,
  input  logic        dp_write,
  input  logic [31:0] dp_addr,
  input  logic [31:0] dp_wdata,
  input  logic [3:0]  dp_be,
  output logic [31:0] dp_rdata
);

  localparam int          PAGE_WORDS = PAGE_BYTES / 4;
  localparam int          MAIN_WORDS = PAGE_WORDS * NUM_PAGES;
  localparam int          CFG_WORDS  = CFG_BYTES / 4;
  localparam logic [31:0] MAIN_BYTES = 32'(PAGE_BYTES * NUM_PAGES);
  localparam logic [31:0] CFG_END    = CFG_BASE + 32'(CFG_BYTES);
  localparam int          MIW        = (MAIN_WORDS > 1) ? $clog2(MAIN_WORDS) : 1;
  localparam int          CIW        = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;
  localparam int          PGW        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int          PG_SHIFT   = $clog2(PAGE_BYTES);

  fmode_e     mode;
  erase_cmd_t cmd;

  flashctl_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .rg_valid (rg_valid),
    .rg_write (rg_write),
    .rg_addr  (rg_addr),
    .rg_wdata (rg_wdata),
    .rg_be    (rg_be),
    .rg_rdata (rg_rdata),
    .mode     (mode),
    .cmd      (cmd)
  );

  logic          main_hit, cfg_hit;
  logic [31:0]   cfg_off;
  logic          wr_ok, rd_go;
  logic          pg_in_range;
  logic [PGW-1:0] pg_idx;

  assign main_hit    = dp_addr < MAIN_BYTES;
  assign cfg_hit     = (dp_addr >= CFG_BASE) && (dp_addr < CFG_END);
  assign cfg_off     = dp_addr - CFG_BASE;
  assign wr_ok       = dp_valid && dp_write && (mode == MODE_WR);
  assign rd_go       = dp_valid && !dp_write;
  assign pg_in_range = cmd.pg_addr < MAIN_BYTES;
  assign pg_idx      = cmd.pg_addr[PG_SHIFT +: PGW];

  logic [31:0] main_rd, cfg_rd;

  flashctl_array #(.PAGE_WORDS(PAGE_WORDS), .PAGES(NUM_PAGES)) u_main (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_ok && main_hit),
    .wr_idx    (dp_addr[MIW+1:2]),
    .wr_data   (dp_wdata),
    .wr_be     (dp_be),
    .pg_erase  (cmd.pg_en && pg_in_range),
    .pg_idx    (pg_idx),
    .all_erase (cmd.all_en),
    .rd_en     (rd_go && main_hit),
    .rd_idx    (dp_addr[MIW+1:2]),
    .rd_data   (main_rd)
  );

  flashctl_array #(.PAGE_WORDS(CFG_WORDS), .PAGES(1)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_ok && cfg_hit),
    .wr_idx    (cfg_off[CIW+1:2]),
    .wr_data   (dp_wdata),
    .wr_be     (dp_be),
    .pg_erase  (1'b0),
    .pg_idx    (1'b0),
    .all_erase (cmd.cfg_en),
    .rd_en     (rd_go && cfg_hit),
    .rd_idx    (cfg_off[CIW+1:2]),
    .rd_data   (cfg_rd)
  );

  logic main_sel_q, cfg_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_sel_q <= 1'b0;
      cfg_sel_q  <= 1'b0;
    end else if (rd_go) begin
      main_sel_q <= main_hit;
      cfg_sel_q  <= cfg_hit;
    end
  end

  always_comb begin
    if (main_sel_q)     dp_rdata = main_rd;
    else if (cfg_sel_q) dp_rdata = cfg_rd;
    else                dp_rdata = '0;
  end

  logic unused_bits;
  assign unused_bits = ^{dp_addr[1:0], cfg_off, cmd.pg_addr};

  // R4
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && !dp_write && !main_hit && !cfg_hit) |=> dp_rdata == 32'h0);

  // R8
  erase_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.pg_en || cmd.all_en || cmd.cfg_en) |-> (u_regs.mode_q == MODE_ER));

endmodule

// File: tb/flashctl_test.sv
module flashctl_test;

  localparam int          NPG   = 4;
  localparam int          PGB   = 1024;
  localparam int          MAINB = NPG * PGB;
  localparam int          MWRD  = MAINB / 4;
  localparam int          CFGB  = 256;
  localparam int          CWRD  = CFGB / 4;
  localparam logic [31:0] CBASE = 32'h1000_1000;

  logic        clk = 1'b0;
  logic        rst;
  logic        rg_valid, rg_write;
  logic [11:0] rg_addr;
  logic [31:0] rg_wdata;
  logic [3:0]  rg_be;
  logic [31:0] rg_rdata;
  logic        dp_valid, dp_write;
  logic [31:0] dp_addr, dp_wdata;
  logic [3:0]  dp_be;
  logic [31:0] dp_rdata;

  always #5 clk = ~clk;

  flashctl uut (
    .clk(clk), .rst(rst),
    .rg_valid(rg_valid), .rg_write(rg_write), .rg_addr(rg_addr),
    .rg_wdata(rg_wdata), .rg_be(rg_be), .rg_rdata(rg_rdata),
    .dp_valid(dp_valid), .dp_write(dp_write), .dp_addr(dp_addr),
    .dp_wdata(dp_wdata), .dp_be(dp_be), .dp_rdata(dp_rdata)
  );

  typedef struct {
    logic [31:0] val;
    int          req;
    logic [31:0] where;
  } exp_t;

  exp_t dq[$];
  exp_t rq[$];
  int   total = 0;
  int   bad   = 0;

  logic [31:0] m_main [MWRD];
  logic [31:0] m_cfg  [CWRD];
  logic [1:0]  m_mode;

  // ---------------- driver tasks ----------------
  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    rg_valid = 1'b1; rg_write = 1'b1; rg_addr = a; rg_wdata = d; rg_be = be;
    if (m_mode == 2'd2) begin
      if ((a == 12'h508 || a == 12'h510) && d < MAINB)
        for (int w = 0; w < PGB / 4; w++) m_main[(d / PGB) * (PGB / 4) + w] = '1;
      if (a == 12'h50C && d[0]) for (int w = 0; w < MWRD; w++) m_main[w] = '1;
      if (a == 12'h514 && d[0]) for (int w = 0; w < CWRD; w++) m_cfg[w] = '1;
    end
    if (a == 12'h504 && be[0]) m_mode = d[1:0];
    @(posedge clk); #1;
    rg_valid = 1'b0; rg_write = 1'b0;
  endtask

  task automatic rg_rd(input logic [11:0] a, input int req);
    exp_t e;
    @(negedge clk);
    rg_valid = 1'b1; rg_write = 1'b0; rg_addr = a;
    e.req = req; e.where = {20'b0, a};
    if (a == 12'h400)      e.val = 32'h1;
    else if (a == 12'h504) e.val = {30'b0, m_mode};
    else                   e.val = 32'h0;
    rq.push_back(e);
    @(posedge clk); #1;
    rg_valid = 1'b0;
  endtask

  task automatic dp_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    dp_valid = 1'b1; dp_write = 1'b1; dp_addr = a; dp_wdata = d; dp_be = be;
    if (m_mode == 2'd1) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) begin
          if (a < MAINB)                       m_main[a / 4][8*b +: 8] = d[8*b +: 8];
          else if (a >= CBASE && a < CBASE + CFGB) m_cfg[(a - CBASE) / 4][8*b +: 8] = d[8*b +: 8];
        end
      end
    end
    @(posedge clk); #1;
    dp_valid = 1'b0; dp_write = 1'b0;
  endtask

  task automatic dp_rd(input logic [31:0] a, input int req);
    exp_t e;
    @(negedge clk);
    dp_valid = 1'b1; dp_write = 1'b0; dp_addr = a;
    e.req = req; e.where = a;
    if (a < MAINB)                           e.val = m_main[a / 4];
    else if (a >= CBASE && a < CBASE + CFGB) e.val = m_cfg[(a - CBASE) / 4];
    else                                     e.val = 32'h0;
    dq.push_back(e);
    @(posedge clk); #1;
    dp_valid = 1'b0;
  endtask

  // ---------------- monitor ----------------
  logic dp_rd_prev = 1'b0;
  logic rg_rd_prev = 1'b0;

  always @(posedge clk) begin
    dp_rd_prev <= dp_valid && !dp_write && !rst;
    rg_rd_prev <= rg_valid && !rg_write && !rst;
  end

  always @(negedge clk) begin
    exp_t e;
    if (dp_rd_prev) begin
      total++;
      if (dq.size() == 0) begin
        bad++;
        $display("FAIL data read with no expectation: actual=%08h expected=none", dp_rdata);
      end else begin
        e = dq.pop_front();
        if (dp_rdata !== e.val) begin
          bad++;
          $display("FAIL R%0d data addr=%08h actual=%08h expected=%08h", e.req, e.where, dp_rdata, e.val);
        end
      end
    end
    if (rg_rd_prev) begin
      total++;
      if (rq.size() == 0) begin
        bad++;
        $display("FAIL register read with no expectation: actual=%08h expected=none", rg_rdata);
      end else begin
        e = rq.pop_front();
        if (rg_rdata !== e.val) begin
          bad++;
          $display("FAIL R%0d reg ofs=%03h actual=%08h expected=%08h", e.req, e.where[11:0], rg_rdata, e.val);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int w = 0; w < MWRD; w++) m_main[w] = '1;
    for (int w = 0; w < CWRD; w++) m_cfg[w] = '1;
    m_mode = 2'd0;
    rst = 1'b1;
    rg_valid = 0; rg_write = 0; rg_addr = '0; rg_wdata = '0; rg_be = '0;
    dp_valid = 0; dp_write = 0; dp_addr = '0; dp_wdata = '0; dp_be = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R2 reset mode, R1 ready, R4 blank contents after reset
    rg_rd(12'h504, 2);
    rg_rd(12'h400, 1);
    dp_rd(32'h0, 4);
    dp_rd(MAINB - 4, 4);
    dp_rd(CBASE + 8, 4);

    // R2 mode readback including the reserved value, and byte-enable gating
    reg_wr(12'h504, 32'h3, 4'hF); rg_rd(12'h504, 2);
    reg_wr(12'h504, 32'h0, 4'hF); rg_rd(12'h504, 2);
    reg_wr(12'h504, 32'h1, 4'b0010); rg_rd(12'h504, 2);
    rg_rd(12'h400, 1);

    // R3 write ignored in mode 0
    dp_wr(32'h0, 32'h1234_5678, 4'hF); dp_rd(32'h0, 3);

    // R3 writes in mode 1 across all pages and the configuration region
    reg_wr(12'h504, 32'h1, 4'hF);
    for (int p = 0; p < NPG; p++)
      for (int k = 0; k < 4; k++)
        dp_wr(p * PGB + k * 148, {8'(p), 8'(k), 16'hA5C3}, 4'hF);
    dp_wr(32'h408, 32'hAABB_CCDD, 4'b0010);
    for (int k = 0; k < 4; k++) dp_wr(CBASE + k * 4, 32'hC0DE_0000 + k, 4'hF);
    dp_wr(CBASE + CFGB - 4, 32'h5566_7788, 4'hF);
    dp_wr(32'h2000, 32'hDEAD_BEEF, 4'hF);
    for (int p = 0; p < NPG; p++)
      for (int k = 0; k < 4; k++) dp_rd(p * PGB + k * 148, 3);
    dp_rd(32'h408, 3);
    for (int k = 0; k < 4; k++) dp_rd(CBASE + k * 4, 3);
    dp_rd(CBASE + CFGB - 4, 3);
    // R4 unmapped addresses read zero
    dp_rd(32'h2000, 4);
    dp_rd(MAINB, 4);
    dp_rd(CBASE + CFGB, 4);

    // R8 erases ignored in mode 1 and mode 3
    reg_wr(12'h508, 32'h400, 4'hF);
    reg_wr(12'h50C, 32'h1, 4'hF);
    reg_wr(12'h514, 32'h1, 4'hF);
    dp_rd(32'h400, 8); dp_rd(32'h0, 8); dp_rd(CBASE, 8);
    reg_wr(12'h504, 32'h3, 4'hF);
    reg_wr(12'h510, 32'h0, 4'hF);
    reg_wr(12'h50C, 32'h1, 4'hF);
    reg_wr(12'h514, 32'h1, 4'hF);
    dp_rd(32'h0, 8); dp_rd(32'hC00, 8); dp_rd(CBASE + 4, 8);
    // R3 write ignored in mode 3
    dp_wr(32'h0, 32'h0BAD_0BAD, 4'hF); dp_rd(32'h0, 3);

    // R3 write ignored in mode 2
    reg_wr(12'h504, 32'h2, 4'hF);
    dp_wr(32'h94, 32'h0, 4'hF); dp_rd(32'h94, 3);

    // R5 page erase through the first alias, address mid-page
    reg_wr(12'h508, 32'h437, 4'hF);
    for (int p = 0; p < NPG; p++)
      for (int k = 0; k < 4; k++) dp_rd(p * PGB + k * 148, 5);
    dp_rd(32'h408, 5);
    // R5 page erase through the second alias
    reg_wr(12'h510, 32'hC10, 4'hF);
    for (int k = 0; k < 4; k++) dp_rd(3 * PGB + k * 148, 5);
    dp_rd(2 * PGB, 5);
    // R5 out-of-range page address erases nothing
    reg_wr(12'h508, MAINB, 4'hF);
    dp_rd(32'h0, 5); dp_rd(2 * PGB + 148, 5);

    // R6 full erase needs bit 0, spares the configuration region
    reg_wr(12'h50C, 32'h2, 4'hF);
    dp_rd(32'h0, 6); dp_rd(2 * PGB + 296, 6);
    reg_wr(12'h50C, 32'h1, 4'hF);
    dp_rd(32'h0, 6); dp_rd(2 * PGB + 296, 6); dp_rd(MAINB - 4, 6);
    dp_rd(CBASE, 6); dp_rd(CBASE + CFGB - 4, 6);

    // R7 configuration erase spares the main array
    reg_wr(12'h504, 32'h1, 4'hF);
    dp_wr(32'h10, 32'h7777_1111, 4'hF);
    reg_wr(12'h504, 32'h2, 4'hF);
    reg_wr(12'h514, 32'h1, 4'hF);
    dp_rd(CBASE, 7); dp_rd(CBASE + 12, 7); dp_rd(CBASE + CFGB - 4, 7);
    dp_rd(32'h10, 7);

    // R9 undefined offsets and command offsets read zero, writes have no effect
    reg_wr(12'h600, 32'h5, 4'hF);
    reg_wr(12'h404, 32'h1, 4'hF);
    rg_rd(12'h600, 9); rg_rd(12'h508, 9); rg_rd(12'h50C, 9);
    rg_rd(12'h510, 9); rg_rd(12'h514, 9);
    rg_rd(12'h504, 9);
    dp_rd(32'h10, 9);

    repeat (4) @(negedge clk);
    if (dq.size() != 0 || rq.size() != 0) begin
      total++; bad++;
      $display("FAIL pending reads: actual=%0d expected=0", dq.size() + rq.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule